// File: doc/BRIEF.md
# Age-Replaced Translation Cache

This block is a small, fully associative cache of page translations placed in front of a slower page-table walker. A requester presents a virtual page number and an in-page offset. Every entry compares its stored page number with the request at once. On a match, the block returns that entry's frame base plus the offset one cycle later. On a miss, it issues a lookup to the page table and stalls the requester until the answer returns. It then writes the answer into a victim entry and completes the request with the translated address. In the same cycle it tells the page table to mark the loaded page present.

Each entry carries a saturating age counter. Every completed hit and every fill ages all entries by one. A freshly filled entry restarts at zero. The victim for a miss is the lowest-numbered entry whose age equals the largest age seen when the request was accepted. A page-table fault does not abort the request. The cache is still filled, the base plus offset is still returned, and a fault-serviced flag marks that response.

Top module: `tlb_age_cache`

## Requirements
- R1: After reset, entry i holds page number i and frame base (i mod NFRAMES) * 2^OFF_W. With defaults (8 entries, NFRAMES=10, OFF_W=4), pages 0..7 hit with address 16*i + offset.
- R2: A request accepted while `req_ready`=1 whose page is cached gives `rsp_valid`=1 and `rsp_hit`=1 in the next cycle. It also gives `rsp_addr` = frame base + offset, `rsp_fault_svc`=0, and no page-table request.
- R3: A request that misses raises `pt_req_valid` in the next cycle, carrying the request's page and offset. `pt_req_valid` stays high with stable fields, and `req_ready` stays low, until the cycle in which `pt_rsp_valid` is seen.
- R4: The cycle after `pt_rsp_valid` is seen during a miss, `rsp_valid`=1 and `rsp_hit`=0. `rsp_addr` = `pt_rsp_base` + offset, and `rsp_fault_svc` equals `pt_rsp_fault`.
- R5: In that same completion cycle, `pt_set_valid` is high for exactly one cycle and `pt_set_vpn` carries the filled page. This happens whether or not the lookup faulted.
- R6: Every hit and every fill increments the age of all entries, saturating at 2^AGE_W-1. The entry written by a fill is set to age 0.
- R7: The victim of a miss is the lowest-index entry whose age equals the maximum age over all entries at the moment the request is accepted. The victim's old page misses afterwards, and the new page hits.
- R8: `req_valid` while `req_ready`=0 is ignored and is not serviced later. `pt_rsp_valid` while no lookup is outstanding is ignored and changes neither responses nor entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_vpn | input | VPN_W | Virtual page number |
| req_off | input | OFF_W | Offset within the page |
| req_ready | output | 1 | Block is idle and accepts a request |
| rsp_valid | output | 1 | Translation complete (one cycle) |
| rsp_hit | output | 1 | Completed from a cached entry |
| rsp_fault_svc | output | 1 | Completed after a faulting page-table lookup |
| rsp_addr | output | PA_W | Translated address |
| pt_req_valid | output | 1 | Page-table lookup outstanding |
| pt_req_vpn | output | VPN_W | Page of the lookup |
| pt_req_off | output | OFF_W | Offset of the lookup |
| pt_rsp_valid | input | 1 | Page-table answer present |
| pt_rsp_base | input | PA_W | Frame base returned by the page table |
| pt_rsp_fault | input | 1 | Lookup faulted |
| pt_set_valid | output | 1 | Mark a page present in the page table |
| pt_set_vpn | output | VPN_W | Page to mark present |

## Verification
A fill makes two things happen at one clock edge. All ages step up, and the victim is forced back to zero. In that same cycle, the response and the present-bit update also leave together. The bench provokes this on every miss of a sweep over all sixteen pages, with varied page-table delays and fault patterns. It checks the simultaneous outputs in the completion cycle. It then checks the aging indirectly: a reference model of the ages predicts which page the next miss evicts, and later hits or misses on that page confirm the prediction. A run of hits that drives every counter into saturation, followed by misses, shows whether saturation or wrap-around decides the victim.

// File: rtl/tlb_age_cache.sv
module tlb_age_cache #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 4,
  parameter int OFF_W   = 4,
  parameter int PA_W    = 8,
  parameter int AGE_W   = 4,
  parameter int NFRAMES = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [OFF_W-1:0] req_off,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault_svc,
  output logic [PA_W-1:0]  rsp_addr,
  output logic             pt_req_valid,
  output logic [VPN_W-1:0] pt_req_vpn,
  output logic [OFF_W-1:0] pt_req_off,
  input  logic             pt_rsp_valid,
  input  logic [PA_W-1:0]  pt_rsp_base,
  input  logic             pt_rsp_fault,
  output logic             pt_set_valid,
  output logic [VPN_W-1:0] pt_set_vpn
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [AGE_W-1:0] AGE_TOP = {AGE_W{1'b1}};

  logic [VPN_W-1:0] vpn_q  [ENTRIES];
  logic [PA_W-1:0]  base_q [ENTRIES];
  logic [AGE_W-1:0] age_q  [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0] hit_idx, vict_idx, vict_q;
  logic [AGE_W-1:0] max_age;
  logic             hit, accept, fill;

  function automatic logic [AGE_W-1:0] age_step(input logic [AGE_W-1:0] a);
    return (a == AGE_TOP) ? a : a + 1'b1;
  endfunction

  always_comb begin
    hit_idx = '0;
    max_age = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      match[i] = (vpn_q[i] == req_vpn);
      if (age_q[i] > max_age) max_age = age_q[i];
    end
    for (int i = ENTRIES-1; i >= 0; i--)
      if (match[i]) hit_idx = IDX_W'(i);
    vict_idx = '0;
    for (int i = ENTRIES-1; i >= 0; i--)
      if (age_q[i] == max_age) vict_idx = IDX_W'(i);
  end

  assign hit       = |match;
  assign req_ready = !pt_req_valid;
  assign accept    = req_valid && req_ready;
  assign fill      = pt_req_valid && pt_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]  <= VPN_W'(i);
        base_q[i] <= PA_W'((i % NFRAMES) * (2 ** OFF_W));
        age_q[i]  <= '0;
      end
    end else if (accept && hit) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= age_step(age_q[i]);
    end else if (fill) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == vict_q) begin
          vpn_q[i]  <= pt_req_vpn;
          base_q[i] <= pt_rsp_base;
          age_q[i]  <= '0;
        end else begin
          age_q[i]  <= age_step(age_q[i]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pt_req_valid  <= 1'b0;
      pt_req_vpn    <= '0;
      pt_req_off    <= '0;
      vict_q        <= '0;
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_fault_svc <= 1'b0;
      rsp_addr      <= '0;
      pt_set_valid  <= 1'b0;
      pt_set_vpn    <= '0;
    end else begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_fault_svc <= 1'b0;
      pt_set_valid  <= 1'b0;
      if (accept && hit) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b1;
        rsp_addr  <= base_q[hit_idx] + PA_W'(req_off);
      end else if (accept) begin
        pt_req_valid <= 1'b1;
        pt_req_vpn   <= req_vpn;
        pt_req_off   <= req_off;
        vict_q       <= vict_idx;
      end else if (fill) begin
        pt_req_valid  <= 1'b0;
        rsp_valid     <= 1'b1;
        rsp_fault_svc <= pt_rsp_fault;
        rsp_addr      <= pt_rsp_base + PA_W'(pt_req_off);
        pt_set_valid  <= 1'b1;
        pt_set_vpn    <= pt_req_vpn;
      end
    end
  end

  AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match)); // R2
  AST_HIT_NO_SET: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_hit) |-> !pt_set_valid); // R2
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (pt_req_valid && !pt_rsp_valid) |=> (pt_req_valid && $stable(pt_req_vpn) && $stable(pt_req_off))); // R3
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) pt_req_valid |-> !req_ready); // R3
  AST_FILL_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n) fill |=> (rsp_valid && !rsp_hit && pt_set_valid)); // R4
  AST_SET_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n) pt_set_valid |-> (rsp_valid && !rsp_hit)); // R5
  AST_FILLED_YOUNG: assert property (@(posedge clk) disable iff (!rst_n) pt_set_valid |-> (age_q[vict_q] == '0 && vpn_q[vict_q] == pt_set_vpn)); // R6
  AST_IDLE_RSP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (!pt_req_valid && pt_rsp_valid && !req_valid) |=> !rsp_valid); // R8
endmodule

// File: tb/sim_tlb_age_cache.sv
`timescale 1ns/1ps
module sim_tlb_age_cache;
  localparam int N = 8, VW = 4, OW = 4, PW = 8, AW = 4, NF = 10;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0; logic [VW-1:0] req_vpn = 0; logic [OW-1:0] req_off = 0;
  logic req_ready, rsp_valid, rsp_hit, rsp_fault_svc, pt_req_valid, pt_set_valid;
  logic [PW-1:0] rsp_addr; logic [VW-1:0] pt_req_vpn, pt_set_vpn; logic [OW-1:0] pt_req_off;
  logic pt_rsp_valid = 0; logic [PW-1:0] pt_rsp_base = 0; logic pt_rsp_fault = 0;
  int checks = 0, errors = 0;
  int m_vpn [N]; int m_base [N]; int m_age [N];

  tlb_age_cache #(.ENTRIES(N), .VPN_W(VW), .OFF_W(OW), .PA_W(PW), .AGE_W(AW), .NFRAMES(NF)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn), .req_off(req_off),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault_svc(rsp_fault_svc),
    .rsp_addr(rsp_addr), .pt_req_valid(pt_req_valid), .pt_req_vpn(pt_req_vpn), .pt_req_off(pt_req_off),
    .pt_rsp_valid(pt_rsp_valid), .pt_rsp_base(pt_rsp_base), .pt_rsp_fault(pt_rsp_fault),
    .pt_set_valid(pt_set_valid), .pt_set_vpn(pt_set_vpn));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pt_base(input int p); return (p % NF) * 16; endfunction
  function automatic int pt_fault(input int p); return ((p & 1) ^ ((p >> 3) & 1)); endfunction

  task automatic age_all(input int skip);
    for (int i = 0; i < N; i++)
      if (i != skip && m_age[i] < 15) m_age[i]++;
  endtask

  task automatic do_req(input int v, input int off, input int dly, input bit poke);
    int idx, mx, vic;
    idx = -1;
    for (int i = 0; i < N; i++) if (m_vpn[i] == v && idx < 0) idx = i;
    mx = 0;
    for (int i = 0; i < N; i++) if (m_age[i] > mx) mx = m_age[i];
    vic = -1;
    for (int i = 0; i < N; i++) if (m_age[i] == mx && vic < 0) vic = i;
    @(negedge clk);
    chk("R3", "req_ready idle", req_ready, 1);
    req_valid = 1; req_vpn = VW'(v); req_off = OW'(off);
    @(negedge clk);
    req_valid = 0;
    if (idx >= 0) begin
      chk("R2", "rsp_valid", rsp_valid, 1);
      chk("R2", "rsp_hit", rsp_hit, 1);
      chk("R2", "rsp_addr", rsp_addr, (m_base[idx] + off) & 255);
      chk("R2", "rsp_fault_svc", rsp_fault_svc, 0);
      chk("R2", "no pt_req", pt_req_valid, 0);
      chk("R2", "no pt_set", pt_set_valid, 0);
      age_all(-1);
    end else begin
      chk("R7", "expected miss rsp_valid", rsp_valid, 0);
      chk("R3", "pt_req_valid", pt_req_valid, 1);
      chk("R3", "pt_req_vpn", pt_req_vpn, v);
      chk("R3", "pt_req_off", pt_req_off, off);
      chk("R3", "req_ready busy", req_ready, 0);
      if (poke) begin req_valid = 1; req_vpn = VW'((v + 1) % 8); end
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        chk("R3", "wait pt_req_valid", pt_req_valid, 1);
        chk("R3", "wait pt_req_vpn", pt_req_vpn, v);
        chk("R8", "wait rsp_valid", rsp_valid, 0);
      end
      pt_rsp_valid = 1; pt_rsp_base = PW'(pt_base(v)); pt_rsp_fault = pt_fault(v) != 0;
      @(negedge clk);
      pt_rsp_valid = 0; req_valid = 0;
      chk("R4", "fill rsp_valid", rsp_valid, 1);
      chk("R4", "fill rsp_hit", rsp_hit, 0);
      chk("R4", "fill rsp_addr", rsp_addr, pt_base(v) + off);
      chk("R4", "fill rsp_fault_svc", rsp_fault_svc, pt_fault(v));
      chk("R5", "pt_set_valid", pt_set_valid, 1);
      chk("R5", "pt_set_vpn", pt_set_vpn, v);
      chk("R3", "pt_req dropped", pt_req_valid, 0);
      age_all(vic);
      m_vpn[vic] = v; m_base[vic] = pt_base(v); m_age[vic] = 0;
      if (poke) begin
        @(negedge clk);
        chk("R8", "poked request not serviced", rsp_valid, 0);
        chk("R8", "poked request no lookup", pt_req_valid, 0);
      end
      @(negedge clk);
      chk("R5", "pt_set one cycle", pt_set_valid, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] lf;
    for (int i = 0; i < N; i++) begin m_vpn[i] = i; m_base[i] = (i % NF) * 16; m_age[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset req_ready", req_ready, 1);
    chk("R1", "reset rsp_valid", rsp_valid, 0);
    chk("R1", "reset pt_req_valid", pt_req_valid, 0);
    chk("R1", "reset pt_set_valid", pt_set_valid, 0);
    for (int v = 0; v < N; v++) do_req(v, 15 - v, 0, 0);          // R1 reset contents
    for (int r = 0; r < 4; r++)
      for (int v = 0; v < 16; v++) do_req(v, (v * 3 + r) & 15, r % 3, v == 5); // R6 R7
    @(negedge clk);                                                // R8 stray page-table answer
    pt_rsp_valid = 1; pt_rsp_base = 8'hF0; pt_rsp_fault = 1;
    @(negedge clk);
    pt_rsp_valid = 0;
    chk("R8", "stray pt_rsp no response", rsp_valid, 0);
    chk("R8", "stray pt_rsp no set", pt_set_valid, 0);
    for (int i = 0; i < N; i++) do_req(m_vpn[i], i, 0, 0);
    for (int k = 0; k < 20; k++) do_req(m_vpn[3], k & 15, 0, 0);   // R6 saturation
    for (int v = 0; v < 16; v++) do_req(v, v, 1, 0);
    lf = 8'h5A;
    for (int k = 0; k < 150; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      do_req(lf[3:0], lf[7:4], k % 4, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule